// File: doc/BRIEF.md
# Packet Receive FIFO with Byte-Threshold Ready Flag

This block is a single-clock buffer for a packetized byte stream. Beats arrive on the write side with the data word, start and end markers, an empty-byte count and an error bit. User logic drains them in order through a read side. On the read side, a one-cycle read enable returns a registered beat with a valid strobe. Each stored beat carries a parity bit, computed when the beat is written and checked when it is read.

A ready flag tells the consumer when it is worth starting a read burst. The flag is set when the number of buffered bytes reaches a low-water threshold, counted in bytes rather than words. A static option also sets the flag as soon as any complete packet end is held, so a short packet is not stranded below the threshold. The threshold and the option are sampled once after reset. The block reports reads on an empty buffer, writes to a full buffer and parity mismatches as one-cycle status pulses.

Top module: `pkt_fifo_dav`

## Requirements
- R1: `dav_o` is high exactly when the buffered byte count is at least the threshold. A beat counts as 4 bytes, or 4 minus its empty count when it carries end-of-packet.
- R2: With `eop_early_i` captured high, `dav_o` is also high while at least one beat marked end-of-packet is buffered, even below the threshold. With the option captured low, a buffered packet end below the threshold leaves `dav_o` low.
- R3: A read enable while the buffer holds beats gives, one cycle later, `rd_val_o` high for one cycle. In that cycle the oldest beat appears on `rd_data_o`, `rd_sop_o`, `rd_eop_o` and `rd_err_o`, and beats leave in write order.
- R4: `rd_mty_o` returns the stored empty count, which gives the number of unused high-order byte lanes (0 to 3). The read of an end-of-packet beat lowers the byte count by 4 minus that value.
- R5: A read enable while the buffer is empty raises `underflow_o` for exactly the next cycle, and `rd_val_o` stays low in that cycle.
- R6: A write while 16 beats are held is discarded, and `overflow_o` is high for the next cycle only. The discarded beat is never read out.
- R7: `parity_err_o` is high only alongside a valid read beat whose data does not match its stored parity. Traffic written through the write port never raises it.
- R8: While `rst_ni` is low, all read-side outputs and status outputs are low and the buffer is empty.
- R9: `thresh_i` and `eop_early_i` are captured on the first clock edge after reset is released. Later changes have no effect until the next reset.
- R10: A read and a write in the same cycle on a non-empty, non-full buffer are both carried out, and the byte count reflects both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data, byte 0 in the low bits |
| wr_sop_i | input | 1 | Write beat starts a packet |
| wr_eop_i | input | 1 | Write beat ends a packet |
| wr_mty_i | input | 2 | Unused high byte lanes on an end beat |
| wr_err_i | input | 1 | Error marker carried with the beat |
| thresh_i | input | 7 | Ready threshold in bytes (static) |
| eop_early_i | input | 1 | Raise ready on any buffered packet end (static) |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data |
| rd_val_o | output | 1 | Read beat valid |
| rd_sop_o | output | 1 | Read beat starts a packet |
| rd_eop_o | output | 1 | Read beat ends a packet |
| rd_mty_o | output | 2 | Unused high byte lanes on read end beat |
| rd_err_o | output | 1 | Error marker of read beat |
| dav_o | output | 1 | Enough data buffered to start reading |
| underflow_o | output | 1 | Read attempted on empty buffer (pulse) |
| overflow_o | output | 1 | Write dropped on full buffer (pulse) |
| parity_err_o | output | 1 | Parity mismatch on read beat |

## Verification
The ready flag is first driven by full beats that step the byte count up to and across the threshold, which shows whether the comparison is inclusive. Next, a short packet below the threshold is written once with the early option off and once with it on, which shows whether only the packet end raises the flag. A fill past capacity, with the threshold input changed midway, shows whether full detection drops the right beat and whether the threshold is re-sampled. Interleaved reads and writes, together with a read on an empty buffer, show whether the byte count stays correct under concurrent updates and whether the empty case is handled.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned DATA_W    = BUS_BYTES * 8;
  localparam int unsigned MTY_W     = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sop;
    logic              eop;
    logic [MTY_W-1:0]  mty;
    logic              err;
    logic              par;
  } beat_t;

  function automatic logic [MTY_W:0] beat_bytes(input logic eop, input logic [MTY_W-1:0] mty);
    logic [MTY_W:0] full;
    full = (MTY_W+1)'(BUS_BYTES);
    return eop ? (full - {1'b0, mty}) : full;
  endfunction
endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned EW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  beat_t         wbeat_i,
  input  logic          pop_i,
  output beat_t         head_o,
  output beat_t         rbeat_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [EW-1:0] count_o
);
  beat_t         mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [EW-1:0] cnt_q;
  beat_t         rbeat_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wbeat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      rbeat_q <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_i) begin
        rptr_q  <= ptr_inc(rptr_q);
        rbeat_q <= mem_q[rptr_q];
      end
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign rbeat_o = rbeat_q;
  assign full_o  = (cnt_q == EW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  assert_push_not_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_not_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pkt_fifo_level.sv
module pkt_fifo_level
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned BW   = $clog2(DEPTH * BUS_BYTES + 1),
  localparam int unsigned EW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             push_eop_i,
  input  logic [MTY_W-1:0] push_mty_i,
  input  logic             pop_i,
  input  logic             pop_eop_i,
  input  logic [MTY_W-1:0] pop_mty_i,
  input  logic [BW-1:0]    thresh_i,
  input  logic             eop_early_i,
  output logic             dav_o,
  output logic [BW-1:0]    bytes_o,
  output logic [EW-1:0]    eops_o
);
  logic          init_q;
  logic [BW-1:0] thr_q;
  logic          early_q;
  logic [BW-1:0] bytes_q;
  logic [EW-1:0] eops_q;
  logic [BW-1:0] add_b, sub_b;

  assign add_b = push_i ? BW'(beat_bytes(push_eop_i, push_mty_i)) : '0;
  assign sub_b = pop_i  ? BW'(beat_bytes(pop_eop_i,  pop_mty_i))  : '0;

  // static config: captured once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      thr_q   <= '1;
      early_q <= 1'b0;
    end else if (init_q) begin
      init_q  <= 1'b0;
      thr_q   <= thresh_i;
      early_q <= eop_early_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_q <= '0;
      eops_q  <= '0;
    end else begin
      bytes_q <= bytes_q + add_b - sub_b;
      case ({push_i && push_eop_i, pop_i && pop_eop_i})
        2'b10:   eops_q <= eops_q + 1'b1;
        2'b01:   eops_q <= eops_q - 1'b1;
        default: eops_q <= eops_q;
      endcase
    end
  end

  assign dav_o   = (bytes_q >= thr_q) || (early_q && (eops_q != '0));
  assign bytes_o = bytes_q;
  assign eops_o  = eops_q;

  assert_bytes_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (bytes_q >= sub_b));
endmodule

// File: rtl/pkt_fifo_dav.sv
module pkt_fifo_dav
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned BW   = $clog2(DEPTH * BUS_BYTES + 1),
  localparam int unsigned EW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_sop_i,
  input  logic              wr_eop_i,
  input  logic [MTY_W-1:0]  wr_mty_i,
  input  logic              wr_err_i,
  input  logic [BW-1:0]     thresh_i,
  input  logic              eop_early_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_val_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o,
  output logic [MTY_W-1:0]  rd_mty_o,
  output logic              rd_err_o,
  output logic              dav_o,
  output logic              underflow_o,
  output logic              overflow_o,
  output logic              parity_err_o
);
  beat_t         wbeat, head, rbeat;
  logic          full, empty, do_wr, do_rd;
  logic [EW-1:0] count;
  logic [BW-1:0] bytes;
  logic [EW-1:0] eops;
  logic          val_q, unf_q, ovf_q;

  assign do_wr = wr_en_i && !full;
  assign do_rd = rd_en_i && !empty;

  always_comb begin
    wbeat.data = wr_data_i;
    wbeat.sop  = wr_sop_i;
    wbeat.eop  = wr_eop_i;
    wbeat.mty  = wr_mty_i;
    wbeat.err  = wr_err_i;
    wbeat.par  = ^wr_data_i;
  end

  pkt_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (do_wr),
    .wbeat_i (wbeat),
    .pop_i   (do_rd),
    .head_o  (head),
    .rbeat_o (rbeat),
    .full_o  (full),
    .empty_o (empty),
    .count_o (count)
  );

  pkt_fifo_level #(.DEPTH(DEPTH)) u_level (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (do_wr),
    .push_eop_i  (wr_eop_i),
    .push_mty_i  (wr_mty_i),
    .pop_i       (do_rd),
    .pop_eop_i   (head.eop),
    .pop_mty_i   (head.mty),
    .thresh_i    (thresh_i),
    .eop_early_i (eop_early_i),
    .dav_o       (dav_o),
    .bytes_o     (bytes),
    .eops_o      (eops)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= 1'b0;
      unf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      val_q <= do_rd;
      unf_q <= rd_en_i && empty;
      ovf_q <= wr_en_i && full;
    end
  end

  assign rd_val_o     = val_q;
  assign rd_data_o    = val_q ? rbeat.data : '0;
  assign rd_sop_o     = val_q && rbeat.sop;
  assign rd_eop_o     = val_q && rbeat.eop;
  assign rd_mty_o     = val_q ? rbeat.mty : '0;
  assign rd_err_o     = val_q && rbeat.err;
  assign parity_err_o = val_q && ((^rbeat.data) != rbeat.par);
  assign underflow_o  = unf_q;
  assign overflow_o   = ovf_q;

  assert_underflow_no_val_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> !rd_val_o);
  assert_val_after_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_val_o |-> $past(rd_en_i));
  assert_overflow_after_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(wr_en_i));
  assert_eops_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eops <= count);
  assert_bytes_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(bytes) <= int'(count) * BUS_BYTES) && (int'(bytes) >= int'(count)));
  assert_parity_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_val_o |-> !parity_err_o);
endmodule

// File: tb/pkt_fifo_dav_test.sv
module pkt_fifo_dav_test;
  import pkt_fifo_pkg::*;
  localparam int DEPTH = 16;
  localparam int BW    = $clog2(DEPTH * BUS_BYTES + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, wr_err = 0, rd_en = 0, early = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [MTY_W-1:0]  wr_mty = '0;
  logic [BW-1:0]     thresh = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_val, rd_sop, rd_eop, rd_err, dav, unf, ovf, perr;
  logic [MTY_W-1:0] rd_mty;

  int n_chk = 0, n_bad = 0;
  int m_bytes = 0, m_eops = 0, m_thr = 0;
  bit m_early = 0;
  logic [36:0] mq[$];   // stored beats {data,sop,eop,mty,err}
  logic [36:0] sb[$];   // beats due on the read side next cycle
  logic [31:0] seq = 32'hA500_0000;

  always #5 clk = ~clk;

  pkt_fifo_dav #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_sop_i(wr_sop), .wr_eop_i(wr_eop),
    .wr_mty_i(wr_mty), .wr_err_i(wr_err), .thresh_i(thresh), .eop_early_i(early),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_val_o(rd_val), .rd_sop_o(rd_sop),
    .rd_eop_o(rd_eop), .rd_mty_o(rd_mty), .rd_err_o(rd_err), .dav_o(dav),
    .underflow_o(unf), .overflow_o(ovf), .parity_err_o(perr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [36:0] b);
    return b[3] ? 4 - int'(b[2:1]) : 4;
  endfunction

  // one cycle: drive at negedge, update model after the edge, check at +1
  task automatic step(input bit w, input bit s, input bit e, input int mty, input bit er,
                      input bit r, input string req);
    bit exp_unf, exp_ovf, racc, wacc;
    logic [36:0] nb;
    logic [36:0] hd;
    nb = {seq, s, e, 2'(mty), er};
    wr_en = w; wr_data = seq; wr_sop = s; wr_eop = e; wr_mty = 2'(mty); wr_err = er;
    rd_en = r;
    exp_unf = r && mq.size() == 0;
    exp_ovf = w && mq.size() == DEPTH;
    racc = r && mq.size() > 0;
    wacc = w && mq.size() < DEPTH;
    if (w) seq++;
    @(posedge clk);
    if (racc) begin
      hd = mq.pop_front();
      m_bytes -= nbytes(hd);
      if (hd[3]) m_eops--;
      sb.push_back(hd);
    end
    if (wacc) begin
      mq.push_back(nb);
      m_bytes += nbytes(nb);
      if (nb[3]) m_eops++;
    end
    #1;
    chk({"R5 underflow ", req}, 64'(unf), 64'(exp_unf));
    chk({"R6 overflow ", req}, 64'(ovf), 64'(exp_ovf));
    chk({"R1/R2 dav ", req}, 64'(dav), 64'((m_bytes >= m_thr) || (m_early && m_eops > 0)));
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic do_reset(input int thr, input bit erly);
    @(negedge clk);
    rst_n = 0; thresh = BW'(thr); early = erly;
    #1;
    chk("R8 reset val",  64'(rd_val), 0);
    chk("R8 reset dav",  64'(dav), 0);
    chk("R8 reset flags", 64'({unf, ovf, perr, rd_eop, rd_sop}), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    mq.delete(); sb.delete();
    m_bytes = 0; m_eops = 0; m_thr = thr; m_early = erly;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (rd_val || sb.size() > 0)) begin
      logic [36:0] e;
      if (sb.size() == 0) chk("R3 unexpected valid", 64'(rd_val), 0);
      else begin
        e = sb.pop_front();
        chk("R3 valid", 64'(rd_val), 1);
        chk("R3 data", 64'(rd_data), 64'(e[36:5]));
        chk("R3 sop/eop/err", 64'({rd_sop, rd_eop, rd_err}), 64'({e[4], e[3], e[0]}));
        if (e[3]) chk("R4 mty", 64'(rd_mty), 64'(e[2:1]));
        chk("R7 parity", 64'(perr), 0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset(10, 0);
    // R1: threshold crossing with full beats (4, 8, 12 bytes vs 10)
    step(1, 1, 0, 0, 0, 0, "beat1");
    step(1, 0, 0, 0, 0, 0, "beat2");
    step(1, 0, 0, 0, 0, 0, "beat3 crosses");
    step(0, 0, 0, 0, 0, 1, "rd1");
    step(0, 0, 0, 0, 0, 1, "rd2");
    step(0, 0, 0, 0, 0, 1, "rd3");
    // R2 off / R4: short packet, 5 bytes, no early flag
    step(1, 1, 0, 0, 0, 0, "short sop");
    step(1, 0, 1, 3, 1, 0, "short eop mty3");
    step(0, 0, 0, 0, 0, 1, "rd short a");
    step(0, 0, 0, 0, 0, 1, "rd short b");
    // R5 underflow
    step(0, 0, 0, 0, 0, 1, "read empty");
    step(0, 0, 0, 0, 0, 0, "idle");
    // R6 fill + overflow, R9 threshold change ignored
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 1) thresh = '0;
      step(1, i == 0, i == DEPTH - 1, (i == DEPTH - 1) ? 2 : 0, 0, 0, "fill");
    end
    step(1, 0, 0, 0, 0, 0, "write full dropped");
    chk("R9 threshold held after drain", 64'(m_thr), 10);
    // R10 concurrent read/write
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, "drain");
    for (int i = 0; i < 6; i++) step(1, i == 0, i == 5, (i == 5) ? 1 : 0, 0, 1, "R10 rd+wr");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 0, 1, "drain all");
    step(0, 0, 0, 0, 0, 0, "idle");
    chk("R9 dav low at zero bytes", 64'(dav), 0);
    // R2 on: 2-byte packet below threshold 20
    do_reset(20, 1);
    step(1, 1, 1, 2, 0, 0, "early eop");
    step(1, 1, 0, 0, 0, 0, "next sop");
    step(0, 0, 0, 0, 0, 1, "rd eop beat");
    step(0, 0, 0, 0, 0, 1, "rd last");
    step(0, 0, 0, 0, 0, 0, "idle");
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule